// File: doc/BRIEF.md
# Converter Serial Port with Busy Flag

This block is the digital side of the serial port of a 16-bit sampling converter. It runs in a three-wire mode where the conversion-start line also acts as the chip select. A rising edge on the start line, while the serial data input is held high, launches a conversion. An internal counter in system clock cycles models the conversion time. While the conversion runs, the data output stays undriven whatever the start line does.

When the counter expires with the start line low, the block drives the data output low. A host with a pull-up on that line sees the falling level as an interrupt. The block then enters acquisition and captures the result word from a test input. Each falling edge of the serial clock presents the next bit of the result, most significant bit first. The line is released after the seventeenth falling edge, or sooner if a new start edge arrives.

The block has four states:
- `ST_IDLE`: undriven, waiting for a start edge.
- `ST_CONVERT`: undriven, timer running.
- `ST_FLAG`: driven low as the busy flag.
- `ST_SHIFT`: driving data bits.

It has these transitions:
- IDLE→CONVERT on a qualified start edge.
- CONVERT→FLAG when the timer expires with the start line low.
- CONVERT→IDLE when the timer expires with the start line high.
- FLAG→SHIFT on the first serial clock fall.
- SHIFT→IDLE after the seventeenth fall.
- FLAG or SHIFT→CONVERT on a qualified start edge.
- FLAG or SHIFT→IDLE on a start edge with the data input low.

All pins are sampled on the system clock through two-flop synchronisers. The serial clock must run at least four times slower than the system clock.

Top module: `adc_busy_spi_port`

## Requirements
- R1: After reset the output enable `sdo_oe_o` is low.
- R2: A rising edge on `cnv_i` while `sdi_i` is low starts nothing. The output stays undriven, and later serial clock falls do not drive it.
- R3: Throughout a conversion `sdo_oe_o` stays low, even if `cnv_i` rises and falls again during it.
- R4: If `cnv_i` is low when the timer expires, the output becomes driven with `sdo_o` = 0. This happens on the clock edge that is CONV_CYCLES+3 edges after the first edge that samples the `cnv_i` rise (counting that edge as 1). On the edge before it, the output is still undriven.
- R5: If `cnv_i` is high when the timer expires, the output stays undriven. Serial clock falls then leave it undriven until a new conversion completes.
- R6: After the busy flag, the n-th falling edge of `sck_i` (n = 1..16) sets `sdo_o` to result bit 16−n, so bit 15 comes first and bit 0 last. `sdo_o` changes only after a serial clock fall.
- R7: The seventeenth serial clock fall after the busy flag releases the output.
- R8: A `cnv_i` rising edge during the busy flag or the data transfer releases the output at once. With `sdi_i` high, it also starts a new conversion, whose busy flag and data follow as in R4 and R6.
- R9: The result word is captured when the conversion completes. Changing `result_i` afterwards does not alter the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_i | input | 1 | Conversion start / chip select, asynchronous |
| sck_i | input | 1 | Serial clock from the host, asynchronous |
| sdi_i | input | 1 | Serial data input, held high for this mode |
| result_i | input | 16 | Conversion result supplied by the test environment |
| sdo_o | output | 1 | Serial data output value |
| sdo_oe_o | output | 1 | Output enable; low models a high-impedance pin |

## Verification
Each pin passes two synchroniser flops and an edge register before the state machine acts on it. A pin change therefore shows at the outputs three system clock edges later. The timer adds CONV_CYCLES edges on top of that.

The bench checks the R4 expiry on both sides: still undriven at edge CONV_CYCLES+2 and driven low at edge CONV_CYCLES+3. Every other result is sampled on a falling system clock edge at least four cycles after the stimulus. That is past the three-edge latency and before the next stimulus, so no check depends on ordering at an active edge.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONVERT,
        ST_FLAG,
        ST_SHIFT
    } port_state_e;

    localparam int CH_CNV = 0;
    localparam int CH_SCK = 1;
    localparam int CH_SDI = 2;
    localparam int N_CH   = 3;

endpackage

// File: rtl/adc_port_sync.sv
module adc_port_sync #(
    parameter int CH     = 3,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] pin_i,
    output logic [CH-1:0] lvl_o,
    output logic [CH-1:0] dly_o
);

    localparam int DEPTH = STAGES + 1;

    for (genvar c = 0; c < CH; c++) begin : g_ch
        logic [DEPTH-1:0] pipe_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe_q <= '0;
            end else begin
                pipe_q <= {pipe_q[DEPTH-2:0], pin_i[c]};
            end
        end

        assign lvl_o[c] = pipe_q[STAGES-1];
        assign dly_o[c] = pipe_q[STAGES];
    end

endmodule

// File: rtl/adc_port_timer.sv
module adc_port_timer #(
    parameter int CONV_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o
);

    localparam int CNT_W = $clog2(CONV_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CONV_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start_i) begin
            cnt_q <= LOAD_VAL;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign done_o = run_q && (cnt_q == '0);

endmodule

// File: rtl/adc_port_shifter.sv
module adc_port_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    input  logic         adv_i,
    output logic         bit_o,
    output logic         spent_o
);

    localparam int CNT_W = $clog2(W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W);
    localparam logic [CNT_W-1:0] PAST_END = CNT_W'(W + 1);

    logic [W-1:0]     shreg_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (load_i) begin
            shreg_q <= word_i;
            cnt_q   <= '0;
        end else if (adv_i && !spent_o) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q != '0 && cnt_q != LAST_BIT) begin
                shreg_q <= {shreg_q[W-2:0], 1'b0};
            end
        end
    end

    assign bit_o   = shreg_q[W-1];
    assign spent_o = (cnt_q == PAST_END);

endmodule

// File: rtl/adc_busy_spi_port.sv
module adc_busy_spi_port
    import adc_port_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 50,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic [DATA_W-1:0] result_i,
    output logic              sdo_o,
    output logic              sdo_oe_o
);

    logic [N_CH-1:0] pin_vec;
    logic [N_CH-1:0] lvl_vec;
    logic [N_CH-1:0] dly_vec;

    logic cnv_lvl;
    logic cnv_rise;
    logic sck_fall;
    logic sdi_ok;
    logic start_req;
    logic timer_start;
    logic conv_done;
    logic cap_load;
    logic bit_adv;
    logic data_bit;
    logic bits_spent;

    port_state_e state_q;
    port_state_e state_d;

    assign pin_vec[CH_CNV] = cnv_i;
    assign pin_vec[CH_SCK] = sck_i;
    assign pin_vec[CH_SDI] = sdi_i;

    adc_port_sync #(
        .CH     (N_CH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_vec),
        .lvl_o (lvl_vec),
        .dly_o (dly_vec)
    );

    assign cnv_lvl  = lvl_vec[CH_CNV];
    assign cnv_rise = lvl_vec[CH_CNV] & ~dly_vec[CH_CNV];
    assign sck_fall = ~lvl_vec[CH_SCK] & dly_vec[CH_SCK];
    assign sdi_ok   = lvl_vec[CH_SDI] & dly_vec[CH_SDI];

    assign start_req   = cnv_rise && sdi_ok;
    assign timer_start = start_req && (state_q != ST_CONVERT);
    assign cap_load    = conv_done && (state_q == ST_CONVERT);
    assign bit_adv     = sck_fall && !cnv_rise &&
                         ((state_q == ST_FLAG) || (state_q == ST_SHIFT));

    adc_port_timer #(
        .CONV_CYCLES (CONV_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (timer_start),
        .done_o  (conv_done)
    );

    adc_port_shifter #(
        .W (DATA_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (cap_load),
        .word_i  (result_i),
        .adv_i   (bit_adv),
        .bit_o   (data_bit),
        .spent_o (bits_spent)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) begin
                    state_d = ST_CONVERT;
                end
            end
            ST_CONVERT: begin
                if (conv_done) begin
                    state_d = cnv_lvl ? ST_IDLE : ST_FLAG;
                end
            end
            ST_FLAG: begin
                if (cnv_rise) begin
                    state_d = sdi_ok ? ST_CONVERT : ST_IDLE;
                end else if (sck_fall) begin
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (cnv_rise) begin
                    state_d = sdi_ok ? ST_CONVERT : ST_IDLE;
                end else if (bits_spent) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        sdo_oe_o = 1'b0;
        sdo_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:    sdo_oe_o = 1'b0;
            ST_CONVERT: sdo_oe_o = 1'b0;
            ST_FLAG: begin
                sdo_oe_o = 1'b1;
                sdo_o    = 1'b0;
            end
            ST_SHIFT: begin
                sdo_oe_o = 1'b1;
                sdo_o    = data_bit;
            end
        endcase
    end

endmodule

// File: rtl/adc_busy_spi_port_chk.sv
module adc_busy_spi_port_chk (
    input logic clk,
    input logic rst_n,
    input logic cnv_rise,
    input logic cnv_lvl,
    input logic sck_fall,
    input logic conv_done,
    input logic sdo_o,
    input logic sdo_oe_o
);

    AST_RELEASE_ON_CNV: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_rise |=> !sdo_oe_o); // R8

    AST_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe_o) |-> !sdo_o); // R4

    AST_EXPIRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> (sdo_oe_o == !$past(cnv_lvl))); // R5

    AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe_o && $past(sdo_oe_o) && !$past(sck_fall)) |-> $stable(sdo_o)); // R6

endmodule

bind adc_busy_spi_port adc_busy_spi_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnv_rise  (cnv_rise),
    .cnv_lvl   (cnv_lvl),
    .sck_fall  (sck_fall),
    .conv_done (conv_done),
    .sdo_o     (sdo_o),
    .sdo_oe_o  (sdo_oe_o)
);

// File: tb/adc_busy_spi_port_bench.sv
module adc_busy_spi_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CONV       = 20;
    localparam int W          = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnv = 1'b0;
    logic         sck = 1'b0;
    logic         sdi = 1'b1;
    logic [W-1:0] result = '0;
    logic         sdo;
    logic         sdo_oe;

    int vectors = 0;
    int miscompares = 0;

    adc_busy_spi_port #(
        .DATA_W      (W),
        .CONV_CYCLES (CONV)
    ) u_adc_busy_spi_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnv_i    (cnv),
        .sck_i    (sck),
        .sdi_i    (sdi),
        .result_i (result),
        .sdo_o    (sdo),
        .sdo_oe_o (sdo_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic report_end();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        miscompares++;
        $display("FAIL watchdog actual=running expected=finished");
        report_end();
    end

    // exp_oe = 0: only the enable is checked; otherwise enable and value
    task automatic check_pin(input string req, input bit exp_oe, input bit exp_sdo);
        bit ok;
        vectors++;
        ok = exp_oe ? (sdo_oe === 1'b1 && sdo === exp_sdo) : (sdo_oe === 1'b0);
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual oe=%b sdo=%b expected oe=%b sdo=%b",
                     req, sdo_oe, sdo, exp_oe, exp_oe ? exp_sdo : 1'bx);
        end
    endtask

    task automatic sck_pulse();
        @(negedge clk) sck = 1'b1;
        repeat (4) @(negedge clk);
        sck = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // launch a conversion and check the expiry edge exactly (R3, R4)
    task automatic convert(input logic [W-1:0] word, input bit wiggle);
        @(negedge clk);
        result = word;
        cnv = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk) cnv = 1'b0;
        if (wiggle) begin
            repeat (4) @(posedge clk);
            @(negedge clk) cnv = 1'b1;
            repeat (3) @(posedge clk);
            @(negedge clk);
            check_pin("R3", 1'b0, 1'b0);
            cnv = 1'b0;
            repeat (CONV - 9) @(posedge clk);
        end else begin
            repeat (CONV - 2) @(posedge clk);
        end
        @(negedge clk);
        check_pin("R3", 1'b0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check_pin("R4", 1'b1, 1'b0);
    endtask

    task automatic read_word(input logic [W-1:0] word);
        for (int n = 1; n <= W; n++) begin
            sck_pulse();
            check_pin("R6", 1'b1, word[W-n]);
        end
        sck_pulse();
        check_pin("R7", 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_pin("R1", 1'b0, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_pin("R1", 1'b0, 1'b0);

        // sweep: walking ones, all-zero, all-one, arithmetic patterns
        for (int k = 0; k < 24; k++) begin
            logic [W-1:0] w;
            if (k < W) w = W'(1) << k;
            else if (k == W) w = '0;
            else if (k == W + 1) w = '1;
            else w = W'(k * 40503 + 4660);
            convert(w, k[0]);
            read_word(w);
        end

        // R9: result input changes after capture
        convert(16'h1234, 1'b0);
        @(negedge clk) result = 16'hEDCB;
        read_word(16'h1234);

        // R8: new start edge in the middle of a transfer
        convert(16'hC3C3, 1'b0);
        for (int n = 1; n <= 5; n++) begin
            sck_pulse();
            check_pin("R6", 1'b1, 16'hC3C3 >> (W - n));
        end
        @(negedge clk);
        result = 16'h7E81;
        cnv = 1'b1;
        repeat (4) @(negedge clk);
        check_pin("R8", 1'b0, 1'b0);
        cnv = 1'b0;
        repeat (CONV + 4) @(negedge clk);
        check_pin("R8", 1'b1, 1'b0);
        read_word(16'h7E81);

        // R8: start edge during the busy flag itself
        convert(16'h0F0F, 1'b0);
        @(negedge clk);
        result = 16'hB00B;
        cnv = 1'b1;
        repeat (4) @(negedge clk);
        check_pin("R8", 1'b0, 1'b0);
        cnv = 1'b0;
        repeat (CONV + 4) @(negedge clk);
        check_pin("R8", 1'b1, 1'b0);
        read_word(16'hB00B);

        // R5: start line still high at expiry
        @(negedge clk);
        result = 16'h5555;
        cnv = 1'b1;
        repeat (CONV + 8) @(negedge clk);
        check_pin("R5", 1'b0, 1'b0);
        cnv = 1'b0;
        repeat (8) @(negedge clk);
        check_pin("R5", 1'b0, 1'b0);
        sck_pulse();
        check_pin("R5", 1'b0, 1'b0);

        // R2: start edge with the data input low
        @(negedge clk) sdi = 1'b0;
        repeat (4) @(negedge clk);
        cnv = 1'b1;
        repeat (4) @(negedge clk);
        cnv = 1'b0;
        repeat (CONV + 8) @(negedge clk);
        check_pin("R2", 1'b0, 1'b0);
        sck_pulse();
        check_pin("R2", 1'b0, 1'b0);
        sdi = 1'b1;
        repeat (4) @(negedge clk);

        // normal operation after the corner cases
        convert(16'h8001, 1'b1);
        read_word(16'h8001);

        report_end();
    end

endmodule